// File: doc/BRIEF.md
# Control Endpoint Transfer Tracker

This block keeps the progress counters for both directions of a USB device's default control endpoint. Software programs a byte budget, a packet budget and, on the receive side, a budget of back-to-back SETUP packets. It then hands the endpoint to hardware by setting an enable bit. While the endpoint is enabled, single-cycle strobes from the FIFO interfaces count these budgets down: a packet pushed into the transmit FIFO, a packet popped from it, or a packet pushed into the receive FIFO. Each strobe carries a byte length where one applies.

Each direction keeps a small set of write-1-to-clear event flags: transfer finished, endpoint disabled on request and, on the receive side, SETUP stage finished and SETUP budget exceeded. A single interrupt line is the OR of all flags that are not masked. When the byte budget runs out, hardware hands the registers back to software by clearing the enable bit. A register port with a flat address space gives software access to the budgets, the enables, the flags and the masks.

Top module: `ep0_progress_tracker`

## Requirements
- R1: After reset every register (addresses 0 to 5) reads 0 and `irq_o` is low.
- R2: While the IN side is enabled (CTRL bit 0), each `tx_push_i` lowers the IN byte field (IN_SIZE bits 6:0, address 0) by `tx_push_len_i`, stopping at 0. Pushes while the IN side is disabled leave the field unchanged.
- R3: While the IN side is enabled, each `tx_pop_i` lowers the IN packet field (IN_SIZE bits 9:8) by one, stopping at 0.
- R4: A push that brings the byte field of an enabled direction to 0 sets that direction's done flag (bit 0) and clears its enable bit in the same cycle.
- R5: While the OUT side is enabled (CTRL bit 1), each `rx_push_i` lowers the OUT byte field (OUT_SIZE bits 6:0, address 1) by `rx_push_len_i`, stopping at 0, and clears the OUT packet bit (OUT_SIZE bit 8).
- R6: Each `setup_rx_i` lowers the SETUP budget (OUT_SIZE bits 11:10; 1, 2 or 3 packets). When the budget is already 0, a further SETUP leaves it at 0 and sets the OUT overflow flag (bit 4).
- R7: The first `token_rx_i` after one or more SETUP packets sets the OUT SETUP-done flag (bit 3). A later token with no new SETUP in between does not set it again.
- R8: Writing CTRL with bit 2 (IN) or bit 3 (OUT) set while that side is enabled clears its enable bit and sets its disabled flag (bit 1).
- R9: Writes to IN_SIZE or OUT_SIZE are ignored while the matching side is enabled.
- R10: The flag registers (IN at address 3, OUT at address 4) are write-1-to-clear, and bit 2 always reads 0. A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R11: `irq_o` is high exactly when some flag is set whose mask bit is set. MASK is at address 5: bits 4:0 mask the IN flags and bits 12:8 mask the OUT flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 13 | Register write data |
| reg_rdata_o | output | 13 | Register read data (combinational from address) |
| tx_push_i | input | 1 | Packet written into the transmit FIFO |
| tx_push_len_i | input | SIZE_W | Byte length of that packet |
| tx_pop_i | input | 1 | Packet read out of the transmit FIFO |
| rx_push_i | input | 1 | Packet written into the receive FIFO |
| rx_push_len_i | input | SIZE_W | Byte length of that packet |
| setup_rx_i | input | 1 | SETUP packet received |
| token_rx_i | input | 1 | Non-SETUP token seen on the endpoint |
| irq_o | output | 1 | Masked OR of all event flags |

## Verification
A software write-1-to-clear of a flag can land in the same cycle as the hardware event that sets that flag. The bench provokes this by pulsing `token_rx_i` after a SETUP while, in the same cycle, writing 1 to bit 3 of the OUT flag register. It expects bit 3 to read back as 1 afterwards. A SETUP arriving with an empty budget is also driven, and the bench checks that the overflow flag appears while the budget stays at 0. In the same pass it checks that the interrupt line follows the mask.

// File: rtl/ep0_tracker_pkg.sv
`timescale 1ns/1ps
package ep0_tracker_pkg;
   localparam int unsigned FLAG_W       = 5;
   localparam int unsigned FLG_DONE     = 0;
   localparam int unsigned FLG_DIS      = 1;
   localparam int unsigned FLG_SUPDONE  = 3;
   localparam int unsigned FLG_SUPOVF   = 4;
   localparam int unsigned PKT_LSB      = 8;
   localparam int unsigned SUP_LSB      = 10;
   localparam int unsigned OUT_MASK_LSB = 8;
   localparam int unsigned REG_W        = OUT_MASK_LSB + FLAG_W;
   localparam int unsigned ADDR_W       = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_IN_SIZE  = 3'd0,
      REG_OUT_SIZE = 3'd1,
      REG_CTRL     = 3'd2,
      REG_IN_FLG   = 3'd3,
      REG_OUT_FLG  = 3'd4,
      REG_MASK     = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/ep0_evt_flags.sv
`timescale 1ns/1ps
module ep0_evt_flags #(
   parameter int unsigned         W         = 5,
   parameter logic [W-1:0]        LIVE_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE_MASK[i]) begin : g_live
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end
         assign flag_o[i] = q;
      end else begin : g_tied
         assign flag_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/ep0_in_counter.sv
`timescale 1ns/1ps
module ep0_in_counter #(
   parameter int unsigned SIZE_W = 7,
   parameter int unsigned PKT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              load_i,
   input  logic [SIZE_W-1:0] load_size_i,
   input  logic [PKT_W-1:0]  load_pkt_i,
   input  logic              push_i,
   input  logic [SIZE_W-1:0] push_len_i,
   input  logic              pop_i,
   output logic [SIZE_W-1:0] size_o,
   output logic [PKT_W-1:0]  pkt_o,
   output logic              done_o
);
   logic [SIZE_W-1:0] size_q;
   logic [PKT_W-1:0]  pkt_q;
   logic              take;
   logic              exhaust;

   assign take    = push_i && en_i;
   assign exhaust = take && (push_len_i >= size_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= '0;
         pkt_q  <= '0;
      end else if (load_i) begin
         size_q <= load_size_i;
         pkt_q  <= load_pkt_i;
      end else begin
         if (take)
            size_q <= exhaust ? '0 : size_q - push_len_i;
         if (pop_i && en_i && (pkt_q != '0))
            pkt_q <= pkt_q - 1'b1;
      end
   end

   assign size_o = size_q;
   assign pkt_o  = pkt_q;
   assign done_o = exhaust;
endmodule

// File: rtl/ep0_out_counter.sv
`timescale 1ns/1ps
module ep0_out_counter #(
   parameter int unsigned SIZE_W = 7,
   parameter int unsigned SUP_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              load_i,
   input  logic [SIZE_W-1:0] load_size_i,
   input  logic              load_pkt_i,
   input  logic [SUP_W-1:0]  load_sup_i,
   input  logic              push_i,
   input  logic [SIZE_W-1:0] push_len_i,
   input  logic              setup_i,
   input  logic              token_i,
   output logic [SIZE_W-1:0] size_o,
   output logic              pkt_o,
   output logic [SUP_W-1:0]  sup_o,
   output logic              done_o,
   output logic              sup_done_o,
   output logic              sup_ovf_o
);
   logic [SIZE_W-1:0] size_q;
   logic              pkt_q;
   logic [SUP_W-1:0]  sup_q;
   logic              seen_q;
   logic              take;
   logic              exhaust;
   logic              stage_end;

   assign take      = push_i && en_i;
   assign exhaust   = take && (push_len_i >= size_q);
   assign stage_end = token_i && !setup_i && seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= '0;
         pkt_q  <= 1'b0;
      end else if (load_i) begin
         size_q <= load_size_i;
         pkt_q  <= load_pkt_i;
      end else if (take) begin
         size_q <= exhaust ? '0 : size_q - push_len_i;
         pkt_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       sup_q <= '0;
      else if (load_i)                  sup_q <= load_sup_i;
      else if (setup_i && sup_q != '0)  sup_q <= sup_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (setup_i)   seen_q <= 1'b1;
      else if (stage_end) seen_q <= 1'b0;
   end

   assign size_o     = size_q;
   assign pkt_o      = pkt_q;
   assign sup_o      = sup_q;
   assign done_o     = exhaust;
   assign sup_done_o = stage_end;
   assign sup_ovf_o  = setup_i && (sup_q == '0);
endmodule

// File: rtl/ep0_progress_tracker.sv
`timescale 1ns/1ps
module ep0_progress_tracker
   import ep0_tracker_pkg::*;
#(
   parameter int unsigned SIZE_W   = 7,
   parameter int unsigned IN_PKT_W = 2,
   parameter int unsigned SUP_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   input  logic              tx_push_i,
   input  logic [SIZE_W-1:0] tx_push_len_i,
   input  logic              tx_pop_i,
   input  logic              rx_push_i,
   input  logic [SIZE_W-1:0] rx_push_len_i,
   input  logic              setup_rx_i,
   input  logic              token_rx_i,
   output logic              irq_o
);
   localparam logic [FLAG_W-1:0] IN_LIVE  = 5'b00011;
   localparam logic [FLAG_W-1:0] OUT_LIVE = 5'b11011;

   if (SIZE_W < 1 || SIZE_W > PKT_LSB) begin : g_bad_size
      $error("SIZE_W must fit below the packet field");
   end
   if (IN_PKT_W < 1 || IN_PKT_W > SUP_LSB - PKT_LSB) begin : g_bad_pkt
      $error("IN_PKT_W must fit below the SETUP field");
   end
   if (SUP_W < 1 || SUP_LSB + SUP_W > REG_W) begin : g_bad_sup
      $error("SUP_W does not fit the register width");
   end

   logic wr_in_size, wr_out_size, wr_ctrl, wr_in_flg, wr_out_flg, wr_mask;
   assign wr_in_size  = reg_wr_i && (reg_addr_i == REG_IN_SIZE);
   assign wr_out_size = reg_wr_i && (reg_addr_i == REG_OUT_SIZE);
   assign wr_ctrl     = reg_wr_i && (reg_addr_i == REG_CTRL);
   assign wr_in_flg   = reg_wr_i && (reg_addr_i == REG_IN_FLG);
   assign wr_out_flg  = reg_wr_i && (reg_addr_i == REG_OUT_FLG);
   assign wr_mask     = reg_wr_i && (reg_addr_i == REG_MASK);

   logic                in_en_q, out_en_q;
   logic [SIZE_W-1:0]   in_size, out_size;
   logic [IN_PKT_W-1:0] in_pkt;
   logic                out_pkt;
   logic [SUP_W-1:0]    out_sup;
   logic                in_done, out_done, sup_done, sup_ovf;
   logic                in_dis_req, out_dis_req;
   logic [FLAG_W-1:0]   in_flags, out_flags, in_mask_q, out_mask_q;
   logic [FLAG_W-1:0]   in_set, out_set, in_clr, out_clr;

   ep0_in_counter #(.SIZE_W(SIZE_W), .PKT_W(IN_PKT_W)) u_in (
      .clk(clk), .rst_n(rst_n), .en_i(in_en_q),
      .load_i(wr_in_size && !in_en_q),
      .load_size_i(reg_wdata_i[SIZE_W-1:0]),
      .load_pkt_i(reg_wdata_i[PKT_LSB +: IN_PKT_W]),
      .push_i(tx_push_i), .push_len_i(tx_push_len_i), .pop_i(tx_pop_i),
      .size_o(in_size), .pkt_o(in_pkt), .done_o(in_done)
   );

   ep0_out_counter #(.SIZE_W(SIZE_W), .SUP_W(SUP_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en_i(out_en_q),
      .load_i(wr_out_size && !out_en_q),
      .load_size_i(reg_wdata_i[SIZE_W-1:0]),
      .load_pkt_i(reg_wdata_i[PKT_LSB]),
      .load_sup_i(reg_wdata_i[SUP_LSB +: SUP_W]),
      .push_i(rx_push_i), .push_len_i(rx_push_len_i),
      .setup_i(setup_rx_i), .token_i(token_rx_i),
      .size_o(out_size), .pkt_o(out_pkt), .sup_o(out_sup),
      .done_o(out_done), .sup_done_o(sup_done), .sup_ovf_o(sup_ovf)
   );

   assign in_dis_req  = wr_ctrl && reg_wdata_i[2] && in_en_q;
   assign out_dis_req = wr_ctrl && reg_wdata_i[3] && out_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_en_q  <= 1'b0;
         out_en_q <= 1'b0;
      end else begin
         if (in_done || in_dis_req)          in_en_q <= 1'b0;
         else if (wr_ctrl && reg_wdata_i[0]) in_en_q <= 1'b1;
         if (out_done || out_dis_req)        out_en_q <= 1'b0;
         else if (wr_ctrl && reg_wdata_i[1]) out_en_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_mask_q  <= '0;
         out_mask_q <= '0;
      end else if (wr_mask) begin
         in_mask_q  <= reg_wdata_i[FLAG_W-1:0];
         out_mask_q <= reg_wdata_i[OUT_MASK_LSB +: FLAG_W];
      end
   end

   always_comb begin
      in_set  = '0;
      out_set = '0;
      in_set[FLG_DONE]       = in_done;
      in_set[FLG_DIS]        = in_dis_req;
      out_set[FLG_DONE]      = out_done;
      out_set[FLG_DIS]       = out_dis_req;
      out_set[FLG_SUPDONE]   = sup_done;
      out_set[FLG_SUPOVF]    = sup_ovf;
      in_clr  = wr_in_flg  ? reg_wdata_i[FLAG_W-1:0] : '0;
      out_clr = wr_out_flg ? reg_wdata_i[FLAG_W-1:0] : '0;
   end

   ep0_evt_flags #(.W(FLAG_W), .LIVE_MASK(IN_LIVE)) u_in_flags (
      .clk(clk), .rst_n(rst_n), .set_i(in_set), .clr_i(in_clr), .flag_o(in_flags)
   );
   ep0_evt_flags #(.W(FLAG_W), .LIVE_MASK(OUT_LIVE)) u_out_flags (
      .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_i(out_clr), .flag_o(out_flags)
   );

   assign irq_o = |(in_flags & in_mask_q) | |(out_flags & out_mask_q);

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         REG_IN_SIZE: begin
            reg_rdata_o[SIZE_W-1:0]          = in_size;
            reg_rdata_o[PKT_LSB +: IN_PKT_W] = in_pkt;
         end
         REG_OUT_SIZE: begin
            reg_rdata_o[SIZE_W-1:0]       = out_size;
            reg_rdata_o[PKT_LSB]          = out_pkt;
            reg_rdata_o[SUP_LSB +: SUP_W] = out_sup;
         end
         REG_CTRL: begin
            reg_rdata_o[0] = in_en_q;
            reg_rdata_o[1] = out_en_q;
         end
         REG_IN_FLG:  reg_rdata_o[FLAG_W-1:0] = in_flags;
         REG_OUT_FLG: reg_rdata_o[FLAG_W-1:0] = out_flags;
         REG_MASK: begin
            reg_rdata_o[FLAG_W-1:0]              = in_mask_q;
            reg_rdata_o[OUT_MASK_LSB +: FLAG_W]  = out_mask_q;
         end
         default: reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/ep0_progress_tracker_sva.sv
`timescale 1ns/1ps
module ep0_progress_tracker_sva
   import ep0_tracker_pkg::*;
#(
   parameter int unsigned SIZE_W   = 7,
   parameter int unsigned IN_PKT_W = 2,
   parameter int unsigned SUP_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr_i,
   input logic [ADDR_W-1:0]   reg_addr_i,
   input logic [REG_W-1:0]    reg_wdata_i,
   input logic                setup_rx_i,
   input logic                token_rx_i,
   input logic                irq_o,
   input logic                in_en_q,
   input logic [SIZE_W-1:0]   in_size,
   input logic [IN_PKT_W-1:0] in_pkt,
   input logic [SUP_W-1:0]    out_sup,
   input logic [FLAG_W-1:0]   in_flags,
   input logic [FLAG_W-1:0]   out_flags
);
   assert_size_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_en_q && !(reg_wr_i && reg_addr_i == REG_IN_SIZE)) |=> $stable(in_size));

   assert_pkt_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_en_q |=> (in_pkt <= $past(in_pkt)));

   assert_done_drops_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_flags[FLG_DONE]) |-> !in_en_q);

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_rx_i && out_sup == '0) |=> (out_flags[FLG_SUPOVF] && out_sup == '0));

   assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == REG_CTRL && reg_wdata_i[2] && in_en_q)
      |=> (!in_en_q && in_flags[FLG_DIS]));

   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == REG_OUT_FLG && reg_wdata_i[FLG_SUPDONE] && !token_rx_i)
      |=> !out_flags[FLG_SUPDONE]);

   assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flags == '0 && out_flags == '0) |-> !irq_o);
endmodule

bind ep0_progress_tracker ep0_progress_tracker_sva #(
   .SIZE_W(SIZE_W), .IN_PKT_W(IN_PKT_W), .SUP_W(SUP_W)
) u_sva (
   .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
   .reg_wdata_i(reg_wdata_i), .setup_rx_i(setup_rx_i), .token_rx_i(token_rx_i),
   .irq_o(irq_o), .in_en_q(in_en_q), .in_size(in_size), .in_pkt(in_pkt),
   .out_sup(out_sup), .in_flags(in_flags), .out_flags(out_flags)
);

// File: tb/ep0_progress_tracker_bench.sv
`timescale 1ns/1ps
module ep0_progress_tracker_bench;
   localparam int SW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [12:0]   reg_wdata = '0;
   logic [12:0]   reg_rdata;
   logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
   logic [SW-1:0] tx_len = '0, rx_len = '0;
   logic          setup_rx = 1'b0, token_rx = 1'b0;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ep0_progress_tracker u_ep0_progress_tracker (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .tx_push_i(tx_push), .tx_push_len_i(tx_len), .tx_pop_i(tx_pop),
      .rx_push_i(rx_push), .rx_push_len_i(rx_len),
      .setup_rx_i(setup_rx), .token_rx_i(token_rx), .irq_o(irq)
   );

   typedef struct packed {
      logic [6:0] size;
      logic [1:0] pkt;
      logic [6:0] l1;
      logic [6:0] l2;
      logic [6:0] exp_size;
      logic [1:0] exp_pkt;
      logic       exp_done;
      logic       exp_en;
   } vec_t;

   localparam vec_t VEC [0:4] = '{
      '{7'd64,  2'd3, 7'd8,  7'd8,  7'd48, 2'd2, 1'b0, 1'b1},
      '{7'd10,  2'd1, 7'd4,  7'd6,  7'd0,  2'd0, 1'b1, 1'b0},
      '{7'd5,   2'd0, 7'd8,  7'd0,  7'd0,  2'd0, 1'b1, 1'b0},
      '{7'd127, 2'd2, 7'd64, 7'd64, 7'd0,  2'd1, 1'b1, 1'b0},
      '{7'd20,  2'd3, 7'd0,  7'd0,  7'd20, 2'd2, 1'b0, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 13'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      reg_addr = 3'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic push_tx(input int len);
      @(negedge clk);
      tx_push = 1'b1; tx_len = SW'(len);
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic push_rx(input int len);
      @(negedge clk);
      rx_push = 1'b1; rx_len = SW'(len);
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_tx();
      @(negedge clk); tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic setup_pulse();
      @(negedge clk); setup_rx = 1'b1;
      @(negedge clk); setup_rx = 1'b0;
   endtask

   task automatic token_pulse();
      @(negedge clk); token_rx = 1'b1;
      @(negedge clk); token_rx = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         chk($sformatf("R1 reg%0d after reset", a), v, 0);
      end
      chk("R1 irq after reset", int'(irq), 0);

      // R2 R3 R4: vector table on the IN side
      for (int i = 0; i < 5; i++) begin
         wr(0, (int'(VEC[i].pkt) << 8) | int'(VEC[i].size));
         wr(2, 1);
         pop_tx();
         push_tx(int'(VEC[i].l1));
         push_tx(int'(VEC[i].l2));
         rd(0, v);
         chk($sformatf("R2 vec%0d IN bytes", i), v & 'h7f, int'(VEC[i].exp_size));
         chk($sformatf("R3 vec%0d IN packets", i), (v >> 8) & 3, int'(VEC[i].exp_pkt));
         rd(3, v);
         chk($sformatf("R4 vec%0d done flag", i), v & 1, int'(VEC[i].exp_done));
         rd(2, v);
         chk($sformatf("R4 vec%0d enable", i), v & 1, int'(VEC[i].exp_en));
         if (VEC[i].exp_en) wr(2, 4);
         wr(3, 'h1f);
      end

      // R2: push while disabled is ignored (last vector left 20 bytes)
      push_tx(5);
      rd(0, v);
      chk("R2 push while disabled", v & 'h7f, 20);

      // R9: size write ignored while enabled
      wr(0, 30);
      wr(2, 1);
      wr(0, 5);
      rd(0, v);
      chk("R9 write while enabled", v & 'h7f, 30);

      // R8: disable request
      wr(2, 4);
      rd(2, v);
      chk("R8 IN enable cleared", v & 1, 0);
      rd(3, v);
      chk("R8 IN disabled flag", v, 2);
      wr(3, 'h1f);
      rd(3, v);
      chk("R10 IN flags cleared by w1c", v, 0);

      // R5: OUT receive path
      wr(1, (3 << 10) | (1 << 8) | 64);
      wr(2, 2);
      push_rx(8);
      rd(1, v);
      chk("R5 OUT size after push", v, (3 << 10) | 56);

      // R11: mask only OUT, no flags yet
      wr(5, 'h1f << 8);
      chk("R11 irq quiet with no flags", int'(irq), 0);

      // R6: SETUP budget
      setup_pulse(); setup_pulse(); setup_pulse();
      rd(1, v);
      chk("R6 budget spent", (v >> 10) & 3, 0);
      rd(4, v);
      chk("R6 no overflow yet", (v >> 4) & 1, 0);
      setup_pulse();
      rd(4, v);
      chk("R6 overflow flag", (v >> 4) & 1, 1);
      rd(1, v);
      chk("R6 budget stays 0", (v >> 10) & 3, 0);
      chk("R11 irq on unmasked flag", int'(irq), 1);

      // R7: SETUP stage completion
      token_pulse();
      rd(4, v);
      chk("R7 setup done set", (v >> 3) & 1, 1);
      wr(4, 'h18);
      rd(4, v);
      chk("R10 w1c clears bits 3 and 4", v, 0);
      token_pulse();
      rd(4, v);
      chk("R7 second token no set", (v >> 3) & 1, 0);

      // R10: hardware set beats software clear in the same cycle
      setup_pulse();
      wr(4, 'h1f);
      @(negedge clk);
      token_rx = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 13'h08;
      @(negedge clk);
      token_rx = 1'b0; reg_wr = 1'b0;
      rd(4, v);
      chk("R10 set wins over clear", (v >> 3) & 1, 1);
      chk("R10 reserved bit reads 0", (v >> 2) & 1, 0);

      // R4 on OUT: finish the byte budget
      push_rx(56);
      rd(1, v);
      chk("R5 OUT bytes reach 0", v & 'h7f, 0);
      rd(4, v);
      chk("R4 OUT done flag", v & 1, 1);
      rd(2, v);
      chk("R4 OUT enable cleared", (v >> 1) & 1, 0);

      // R11: masking everything silences irq
      wr(5, 0);
      chk("R11 irq masked", int'(irq), 0);
      wr(5, 1 << 8);
      chk("R11 irq on OUT done", int'(irq), 1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule